// File: doc/BRIEF.md
# Circular Converter Result Buffer

This block keeps the most recent results of an analog-to-digital converter in a four-slot ring so that software can collect several samples with one interrupt. The converter delivers a result word with a one-cycle strobe; the block stores it at the write slot and advances that slot. Software reads the buffered words one byte at a time through a byte-wide port. One of the two byte reads, chosen by the justification mode, consumes the entry and moves the read slot forward.

Status outputs report whether unread data is present and whether an unread entry was overwritten. They also give the slot of the next read and raise an interrupt flag once a chosen number of writes has landed. A conversion start, from either the software go control or the hardware trigger, re-aligns the ring to slot 0. When buffering is switched off, the block acts as a single result register held in slot 0.

Top module: `adcres_ring`

## Requirements
- R1: With `fifo_on` high, each accepted result goes to the current write slot, which then advances by one and wraps from slot 3 to slot 0. Results read back in slot order starting from the read slot.
- R2: With `fifo_on` low, results always go to slot 0 and both slots stay at 0. A second result that arrives before the first has been consumed sets `ovf`.
- R3: `empty` is 1 exactly when the number of unread entries is 0. That count rises on a write, falls on a consuming read, and is 0 after reset.
- R4: `ovf` is set when a write lands on an unread entry and no consuming read happens in the same cycle (all four slots unread, or one in single mode). It stays set until `ovf_clr`, and a set in the same cycle wins over the clear. Reset clears it.
- R5: `rd_ptr` is the slot of the next read. A consuming read advances it by one with wrap only while `empty` is 0. A consuming read while empty changes nothing.
- R6: When `left_just` is 0, the high byte is {6'b0, result[9:8]}, the low byte is result[7:0], and reading the low byte (`rd_lo`) consumes. When `left_just` is 1, the high byte is result[9:2], the low byte is {result[1:0], 6'b0}, and reading the high byte (`rd_hi`) consumes. The other byte read never moves `rd_ptr`.
- R7: A pulse on `sw_go` or `hw_trig` sets both slots and the unread count to 0, which raises `empty`, and restarts the interrupt write counter. A result strobed in that same cycle is dropped.
- R8: `irq_sel` sets the interrupt rate: code 00 means every write, 01 every second write, 10 every fourth write, and 11 every write. `irq` stays set until `irq_ack`, a set wins over an acknowledge, and reset clears it.
- R9: A write and a consuming read in the same cycle leave the unread count unchanged and never set `ovf`.
- R10: A byte read presents its byte on `rd_byte` after the next clock edge. It reads the slot's contents from before any write in that same cycle, and `rd_byte` holds until the next byte read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_on | input | 1 | 1 = four-slot ring, 0 = single register |
| sw_go | input | 1 | Software conversion start pulse |
| hw_trig | input | 1 | Hardware conversion start pulse |
| res_strobe | input | 1 | Converter result valid, one cycle |
| res_data | input | DATA_W | Converter result word |
| left_just | input | 1 | Byte format and consuming byte select |
| rd_hi | input | 1 | High byte read strobe |
| rd_lo | input | 1 | Low byte read strobe |
| irq_sel | input | 2 | Interrupt write-count code |
| ovf_clr | input | 1 | Clears the overflow flag |
| irq_ack | input | 1 | Clears the interrupt flag |
| rd_byte | output | 8 | Byte returned by the last byte read |
| empty | output | 1 | No unread entries |
| ovf | output | 1 | Unread entry was overwritten |
| rd_ptr | output | AW | Slot of the next read |
| irq | output | 1 | Write-count interrupt flag |

## Verification
The main vector walk interleaves writes, consuming low-byte reads and non-consuming high-byte peeks. This separates pointer motion from data selection, and it drives the ring through a wrap, an overwrite at full occupancy and a read while empty. Directed patterns then repeat byte reads with left justification, where the roles of the two reads swap, and pulse each start source separately to show that both slots return to 0. The remaining patterns are a write paired with a consuming read at full occupancy, which must neither count nor flag, and single-register mode, where a second unread result must flag. Each interrupt code is tried with a write sequence just short of its threshold and then one write that reaches it.

// File: rtl/adcres_pkg.sv
package adcres_pkg;

  typedef enum logic [1:0] {
    IRQ_EACH = 2'b00,
    IRQ_PAIR = 2'b01,
    IRQ_QUAD = 2'b10,
    IRQ_ALT  = 2'b11
  } irq_rate_e;

  // number of writes between interrupt flags for a rate code
  function automatic int unsigned irq_period(input irq_rate_e code);
    case (code)
      IRQ_PAIR: return 2;
      IRQ_QUAD: return 4;
      default:  return 1;
    endcase
  endfunction

endpackage

// File: rtl/adcres_store.sv
module adcres_store #(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 4,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // single write port, registered read port, read-before-write
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/adcres_ctrl.sv
module adcres_ctrl #(
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_on,
  input  logic          start,
  input  logic          wr_in,
  input  logic          adv_in,
  input  logic          ovf_clr,
  output logic          wr_ok,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic          empty,
  output logic          ovf
);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic [AW-1:0] wr_nxt, rd_nxt;
  logic          adv_ok, full, ovf_set;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wr_ok   = wr_in && !start;
  assign adv_ok  = adv_in && !start && (cnt_q != '0);
  assign full    = fifo_on ? (cnt_q == CW'(DEPTH)) : (cnt_q != '0);
  assign ovf_set = wr_ok && !adv_ok && full;

  always_comb begin
    cnt_nxt = cnt_q;
    if (start) begin
      cnt_nxt = '0;
    end else begin
      case ({wr_ok, adv_ok})
        2'b10:   cnt_nxt = full ? cnt_q : cnt_q + 1'b1;
        2'b01:   cnt_nxt = cnt_q - 1'b1;
        default: cnt_nxt = cnt_q;
      endcase
      if (!fifo_on && cnt_nxt > CW'(1)) cnt_nxt = CW'(1);
    end
  end

  always_comb begin
    wr_nxt = wr_ptr;
    rd_nxt = rd_ptr;
    if (start || !fifo_on) begin
      wr_nxt = '0;
      rd_nxt = '0;
    end else begin
      if (wr_ok)  wr_nxt = bump(wr_ptr);
      if (adv_ok) rd_nxt = bump(rd_ptr);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      empty  <= 1'b1;
      ovf    <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      wr_ptr <= wr_nxt;
      rd_ptr <= rd_nxt;
      empty  <= (cnt_nxt == '0);
      if (ovf_set)      ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf);

  p_start_realign_r7: assert property (@(posedge clk) disable iff (rst)
    start |=> (rd_ptr == '0 && wr_ptr == '0 && empty));

  p_pair_no_ovf_r9: assert property (@(posedge clk) disable iff (rst)
    (!ovf && wr_in && adv_in && !empty && !start) |=> !ovf);

  p_single_slot_r2: assert property (@(posedge clk) disable iff (rst)
    !fifo_on |=> (rd_ptr == '0 && wr_ptr == '0));

  p_empty_read_r5: assert property (@(posedge clk) disable iff (rst)
    (empty && fifo_on && !start && !wr_in) |=> ($stable(rd_ptr) && empty));

endmodule

// File: rtl/adcres_irq.sv
module adcres_irq
  import adcres_pkg::*;
#(
  parameter int MAX_PERIOD = 4,
  localparam int TW        = $clog2(MAX_PERIOD + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       wr_ok,
  input  logic [1:0] sel,
  input  logic       ack,
  output logic       irq
);

  logic [TW-1:0] wcnt_q;
  logic [TW-1:0] wcnt_inc;
  logic [TW-1:0] period;
  logic          hit;

  assign period   = TW'(irq_period(irq_rate_e'(sel)));
  assign wcnt_inc = wcnt_q + 1'b1;
  assign hit      = wr_ok && (wcnt_inc >= period);

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (start)      wcnt_q <= '0;
      else if (hit)   wcnt_q <= '0;
      else if (wr_ok) wcnt_q <= wcnt_inc;
      if (hit)      irq <= 1'b1;
      else if (ack) irq <= 1'b0;
    end
  end

  p_irq_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (irq && !ack) |=> irq);

  p_each_write_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && (sel == 2'b00 || sel == 2'b11)) |=> irq);

endmodule

// File: rtl/adcres_ring.sv
module adcres_ring #(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 4,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_on,
  input  logic              sw_go,
  input  logic              hw_trig,
  input  logic              res_strobe,
  input  logic [DATA_W-1:0] res_data,
  input  logic              left_just,
  input  logic              rd_hi,
  input  logic              rd_lo,
  input  logic [1:0]        irq_sel,
  input  logic              ovf_clr,
  input  logic              irq_ack,
  output logic [7:0]        rd_byte,
  output logic              empty,
  output logic              ovf,
  output logic [AW-1:0]     rd_ptr,
  output logic              irq
);

  localparam int PAD_W = 16;

  logic              start, adv_in, any_rd, wr_ok;
  logic [AW-1:0]     wr_ptr;
  logic [DATA_W-1:0] word_q;
  logic              hi_q, left_q;
  logic [PAD_W-1:0]  pad;

  assign start  = sw_go || hw_trig;
  assign adv_in = left_just ? rd_hi : rd_lo;
  assign any_rd = rd_hi || rd_lo;

  adcres_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .fifo_on (fifo_on),
    .start   (start),
    .wr_in   (res_strobe),
    .adv_in  (adv_in),
    .ovf_clr (ovf_clr),
    .wr_ok   (wr_ok),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .empty   (empty),
    .ovf     (ovf)
  );

  adcres_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (wr_ok),
    .waddr (wr_ptr),
    .wdata (res_data),
    .re    (any_rd),
    .raddr (rd_ptr),
    .rdata (word_q)
  );

  adcres_irq #(.MAX_PERIOD(4)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .wr_ok (wr_ok),
    .sel   (irq_sel),
    .ack   (irq_ack),
    .irq   (irq)
  );

  // byte format captured with the read, applied to the registered word
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= 1'b0;
      left_q <= 1'b0;
    end else if (any_rd) begin
      hi_q   <= rd_hi;
      left_q <= left_just;
    end
  end

  assign pad     = left_q ? (PAD_W'(word_q) << (PAD_W - DATA_W)) : PAD_W'(word_q);
  assign rd_byte = hi_q ? pad[15:8] : pad[7:0];

  p_peek_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (fifo_on && !start && (left_just ? (rd_lo && !rd_hi) : (rd_hi && !rd_lo)))
      |=> $stable(rd_ptr));

  p_byte_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!rd_hi && !rd_lo && !res_strobe && !$past(res_strobe)) |=> $stable(rd_byte));

endmodule

// File: tb/test_adcres_ring.sv
module test_adcres_ring;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;

  logic       clk = 1'b0;
  logic       rst, fifo_on, sw_go, hw_trig, res_strobe, left_just, rd_hi, rd_lo, ovf_clr, irq_ack;
  logic [9:0] res_data;
  logic [1:0] irq_sel;
  logic [7:0] rd_byte;
  logic       empty, ovf, irq;
  logic [1:0] rd_ptr;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adcres_ring i_adcres_ring (
    .clk(clk), .rst(rst), .fifo_on(fifo_on), .sw_go(sw_go), .hw_trig(hw_trig),
    .res_strobe(res_strobe), .res_data(res_data), .left_just(left_just),
    .rd_hi(rd_hi), .rd_lo(rd_lo), .irq_sel(irq_sel), .ovf_clr(ovf_clr),
    .irq_ack(irq_ack), .rd_byte(rd_byte), .empty(empty), .ovf(ovf),
    .rd_ptr(rd_ptr), .irq(irq)
  );

  // op codes: 0 idle, 1 write, 2 low byte read, 3 high byte read
  // fields: op, data, check byte, byte, empty, ovf, ptr
  localparam logic [24:0] VEC [NV] = '{
    {2'd1, 10'h155, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0},
    {2'd1, 10'h2AA, 1'b0, 8'h00, 1'b0, 1'b0, 2'd0},
    {2'd3, 10'h000, 1'b1, 8'h01, 1'b0, 1'b0, 2'd0},
    {2'd2, 10'h000, 1'b1, 8'h55, 1'b0, 1'b0, 2'd1},
    {2'd2, 10'h000, 1'b1, 8'hAA, 1'b1, 1'b0, 2'd2},
    {2'd2, 10'h000, 1'b0, 8'h00, 1'b1, 1'b0, 2'd2},
    {2'd1, 10'h3FF, 1'b0, 8'h00, 1'b0, 1'b0, 2'd2},
    {2'd1, 10'h001, 1'b0, 8'h00, 1'b0, 1'b0, 2'd2},
    {2'd1, 10'h080, 1'b0, 8'h00, 1'b0, 1'b0, 2'd2},
    {2'd1, 10'h100, 1'b0, 8'h00, 1'b0, 1'b0, 2'd2},
    {2'd1, 10'h2C3, 1'b0, 8'h00, 1'b0, 1'b1, 2'd2},
    {2'd2, 10'h000, 1'b1, 8'hC3, 1'b0, 1'b1, 2'd3},
    {2'd2, 10'h000, 1'b1, 8'h01, 1'b0, 1'b1, 2'd0},
    {2'd3, 10'h000, 1'b1, 8'h00, 1'b0, 1'b1, 2'd0},
    {2'd2, 10'h000, 1'b1, 8'h80, 1'b0, 1'b1, 2'd1},
    {2'd2, 10'h000, 1'b1, 8'h00, 1'b1, 1'b1, 2'd2}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one cycle of stimulus; returns at the negedge after the edge that took it
  task automatic drv(input logic w, input logic [9:0] d, input logic lo, input logic hi,
                     input logic go, input logic trg, input logic oc, input logic ia);
    res_strobe = w; res_data = d; rd_lo = lo; rd_hi = hi;
    sw_go = go; hw_trig = trg; ovf_clr = oc; irq_ack = ia;
    @(negedge clk);
    res_strobe = 0; rd_lo = 0; rd_hi = 0; sw_go = 0; hw_trig = 0; ovf_clr = 0; irq_ack = 0;
  endtask

  task automatic wr(input logic [9:0] d);
    drv(1, d, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    rst = 1; fifo_on = 1; sw_go = 0; hw_trig = 0; res_strobe = 0; res_data = '0;
    left_just = 0; rd_hi = 0; rd_lo = 0; irq_sel = 2'b00; ovf_clr = 0; irq_ack = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // reset state
    chk("R3", "reset empty", int'(empty), 1);
    chk("R4", "reset ovf", int'(ovf), 0);
    chk("R5", "reset ptr", int'(rd_ptr), 0);
    chk("R8", "reset irq", int'(irq), 0);

    // table walk: R1 R3 R4 R5 R6 R10
    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VEC[i];
      drv(v[24:23] == 2'd1, v[22:13], v[24:23] == 2'd2, v[24:23] == 2'd3, 0, 0, 0, 0);
      if (v[12]) chk("R1/R6/R10", $sformatf("vec %0d byte", i), int'(rd_byte), int'(v[11:4]));
      chk("R3", $sformatf("vec %0d empty", i), int'(empty), int'(v[3]));
      chk("R4", $sformatf("vec %0d ovf", i), int'(ovf), int'(v[2]));
      chk("R5", $sformatf("vec %0d ptr", i), int'(rd_ptr), int'(v[1:0]));
    end

    // R10: byte holds with no read
    @(negedge clk);
    chk("R10", "byte hold", int'(rd_byte), 8'h00);

    // R4: clear
    drv(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R4", "ovf cleared", int'(ovf), 0);

    // R7: software start
    drv(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R7", "go ptr", int'(rd_ptr), 0);
    wr(10'h123);
    wr(10'h1FF);
    drv(0, 0, 1, 0, 0, 0, 0, 0);
    chk("R7", "write slot realigned", int'(rd_byte), 8'h23);
    chk("R7", "ptr after read", int'(rd_ptr), 1);
    drv(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R7", "trig ptr", int'(rd_ptr), 0);
    chk("R7", "trig empty", int'(empty), 1);
    drv(1, 10'h3AA, 0, 0, 1, 0, 0, 0);
    chk("R7", "write with start dropped", int'(empty), 1);

    // R6: left justified
    left_just = 1;
    wr(10'h2C5);
    drv(0, 0, 1, 0, 0, 0, 0, 0);
    chk("R6", "left low byte", int'(rd_byte), 8'h40);
    chk("R6", "left low no advance", int'(rd_ptr), 0);
    drv(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R6", "left high byte", int'(rd_byte), 8'hB1);
    chk("R6", "left high advances", int'(rd_ptr), 1);
    chk("R3", "left empty", int'(empty), 1);
    left_just = 0;

    // R8: thresholds
    drv(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8", "ack", int'(irq), 0);
    irq_sel = 2'b01;
    drv(0, 0, 0, 0, 1, 0, 0, 0);
    wr(10'h001);
    chk("R8", "pair 1st", int'(irq), 0);
    wr(10'h002);
    chk("R8", "pair 2nd", int'(irq), 1);
    drv(0, 0, 0, 0, 0, 0, 0, 1);
    irq_sel = 2'b10;
    drv(0, 0, 0, 0, 1, 0, 0, 0);
    wr(10'h001); wr(10'h002); wr(10'h003);
    chk("R8", "quad 3rd", int'(irq), 0);
    wr(10'h004);
    chk("R8", "quad 4th", int'(irq), 1);
    drv(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8", "quad ack", int'(irq), 0);
    irq_sel = 2'b11;
    drv(0, 0, 0, 0, 1, 0, 0, 0);
    wr(10'h005);
    chk("R8", "code 11 every write", int'(irq), 1);
    drv(0, 0, 0, 0, 0, 0, 0, 1);
    irq_sel = 2'b00;
    wr(10'h006);
    chk("R8", "code 00 every write", int'(irq), 1);

    // R9: write and consuming read at full
    drv(0, 0, 0, 0, 1, 0, 1, 0);
    wr(10'h011); wr(10'h022); wr(10'h033); wr(10'h044);
    drv(1, 10'h055, 1, 0, 0, 0, 0, 0);
    chk("R9", "pair ovf", int'(ovf), 0);
    chk("R10", "read before write", int'(rd_byte), 8'h11);
    chk("R9", "pair ptr", int'(rd_ptr), 1);
    drv(0, 0, 1, 0, 0, 0, 0, 0);
    chk("R1", "ring 2", int'(rd_byte), 8'h22);
    drv(0, 0, 1, 0, 0, 0, 0, 0);
    drv(0, 0, 1, 0, 0, 0, 0, 0);
    chk("R1", "ring 4", int'(rd_byte), 8'h44);
    chk("R9", "count kept", int'(empty), 0);
    drv(0, 0, 1, 0, 0, 0, 0, 0);
    chk("R1", "wrapped slot", int'(rd_byte), 8'h55);
    chk("R9", "empty after four", int'(empty), 1);

    // R2: single register mode
    fifo_on = 0;
    drv(0, 0, 0, 0, 1, 0, 0, 0);
    wr(10'h111);
    chk("R2", "one unread", int'(ovf), 0);
    wr(10'h222);
    chk("R2", "second unread ovf", int'(ovf), 1);
    chk("R2", "ptr held", int'(rd_ptr), 0);
    drv(0, 0, 1, 0, 0, 0, 0, 0);
    chk("R2", "single data", int'(rd_byte), 8'h22);
    chk("R2", "single ptr", int'(rd_ptr), 0);
    chk("R2", "single empty", int'(empty), 1);

    done = 1;
    summary();
  end

endmodule